// File: doc/BRIEF.md
# Isochronous CIP/AM824 Packet Transmitter

This block assembles the quadlet payload of outgoing isochronous audio packets. When a scheduler pulses `pkt_start_i`, the block writes a two-quadlet common isochronous packet header. It then writes a configured number of data blocks. Each block is one frame of audio. A block opens with a MIDI quadlet and continues with one labelled 24-bit PCM quadlet per audio channel, in channel order. The quadlets leave one per cycle on a stream marked with start and end of packet. The packet length in bytes is reported alongside the first quadlet.

The block keeps a running data block count. The header carries the index, modulo 256, of the first block in the packet. The count advances by the number of blocks sent once a packet is complete.

MIDI bytes arrive tagged with a port number from 0 to 7. Each port holds one pending byte. A byte goes out only in a block whose running index modulo 8 equals its port. Every other block carries an empty MIDI marker.

If no sample frame is offered when a packet starts, the block sends a header-only packet and leaves the count alone. Configuration is captured at packet start. The timestamp field is always zero. Link-layer transfer, cycle timing and timestamp computation happen elsewhere.

Top module: `am824_pkt_tx`

## Requirements
- R1: The first quadlet of a packet has bits 31:30 = 00, bits 29:24 = node ID, bits 23:16 = block size in quadlets (audio channels + 1), bits 15:8 = 0, and bits 7:0 = data block count.
- R2: The second quadlet has bits 31:30 = 10, bits 29:24 = 0x10, bits 23:16 = {5'b0, rate code}, and bits 15:0 = 0.
- R3: The header's data block count equals the running count, which starts at 0. After each non-empty packet it grows by the number of blocks sent, wrapping modulo 256.
- R4: Each data block is one MIDI quadlet followed by one quadlet per channel, channels 0 upward. An audio quadlet is 0x40 in bits 31:24 with the channel's sample in bits 23:0. All quadlets of a block come from one sample frame.
- R5: A block with running index n (header count + position in packet) carries 0x81 in bits 31:24, the byte in bits 23:16 and zero below, when port n mod 8 has a pending byte. That byte is then consumed. Otherwise the MIDI quadlet is 0x80000000.
- R6: A port with a pending byte deasserts `midi_ready_o` for that port and keeps the byte unchanged until it is sent. A byte offered while the port is busy is not taken.
- R7: If `frame_valid_i` is low in the cycle `pkt_start_i` is taken, only the two header quadlets are sent, with end-of-packet on the second. The length is 8, no frame is consumed, and the running count is unchanged.
- R8: `q_sop_o` marks exactly the first quadlet and `q_eop_o` exactly the last quadlet of a packet. `len_o` equals 8 + 4·blocks·(channels+1) while `q_sop_o` is high.
- R9: One frame is taken per block, with `frame_ready_o` high only while the MIDI quadlet is being sent. If no frame is offered mid-packet, output pauses and resumes with unchanged content.
- R10: `pkt_start_i` has no effect while a packet is in progress.
- R11: After reset, `q_valid_o` and `frame_ready_o` are low and `midi_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_node_i | input | 6 | Source node ID |
| cfg_nch_i | input | 5 | Audio channels per block, 1..MAX_CH |
| cfg_rate_i | input | 3 | Sample rate code |
| cfg_nblk_i | input | 4 | Blocks per packet, 1..MAX_BLK |
| pkt_start_i | input | 1 | Start-of-packet request |
| frame_valid_i | input | 1 | Sample frame offered |
| frame_data_i | input | MAX_CH*24 | Samples, channel c in bits c*24+23:c*24 |
| frame_ready_o | output | 1 | Frame taken this cycle |
| midi_valid_i | input | 1 | MIDI byte offered |
| midi_port_i | input | 3 | Port of offered byte |
| midi_byte_i | input | 8 | MIDI byte |
| midi_ready_o | output | 1 | Offered port has a free slot |
| q_valid_o | output | 1 | Quadlet valid |
| q_data_o | output | 32 | Quadlet |
| q_sop_o | output | 1 | First quadlet of packet |
| q_eop_o | output | 1 | Last quadlet of packet |
| len_o | output | 10 | Packet length in bytes, valid with q_sop_o |

## Verification
The bench builds the expected quadlet sequence of every packet from the requirements and compares it word by word.

Several packet shapes are used:
- A small four-channel, two-block packet separates header field placement from block layout.
- A full eighteen-channel, eight-block packet exercises the widest block size and length.
- A run of thirty-two packets carries the running count across its wrap at 256.

MIDI bytes on ports that do and do not match upcoming block indices show whether insertion follows the index modulo 8, and whether a second byte is refused. An empty-start packet, a mid-packet frame gap and a start pulse during a packet each isolate one control corner.

// File: rtl/cip_tx_pkg.sv
package cip_tx_pkg;
  typedef enum logic [2:0] {S_IDLE, S_HDR0, S_HDR1, S_MIDI, S_AUD} state_e;
  localparam logic [7:0] LBL_PCM       = 8'h40;
  localparam logic [7:0] LBL_MIDI_NONE = 8'h80;
  localparam logic [7:0] LBL_MIDI_ONE  = 8'h81;
  localparam logic [5:0] FMT_AUDIO     = 6'h10;
  localparam int unsigned SAMPLE_W     = 24;
  localparam int unsigned MIDI_PORTS   = 8;
endpackage

// File: rtl/cip_midi_slots.sv
module cip_midi_slots
  import cip_tx_pkg::*;
#(
  parameter int unsigned PORTS = MIDI_PORTS,
  localparam int unsigned PW = $clog2(PORTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [PW-1:0] wr_port_i,
  input  logic [7:0]    wr_byte_i,
  output logic          wr_ready_o,
  input  logic [PW-1:0] rd_port_i,
  input  logic          rd_take_i,
  output logic          rd_hit_o,
  output logic [7:0]    rd_byte_o
);
  logic [PORTS-1:0] pend_q;
  logic [7:0]       byte_q [PORTS];

  assign wr_ready_o = !pend_q[wr_port_i];
  assign rd_hit_o   = pend_q[rd_port_i];
  assign rd_byte_o  = byte_q[rd_port_i];

  for (genvar p = 0; p < PORTS; p++) begin : g_slot
    logic set_w, clr_w;
    assign set_w = wr_valid_i && wr_ready_o && (wr_port_i == PW'(p));
    assign clr_w = rd_take_i && (rd_port_i == PW'(p)) && pend_q[p];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[p] <= 1'b0;
        byte_q[p] <= '0;
      end else if (set_w) begin
        pend_q[p] <= 1'b1;
        byte_q[p] <= wr_byte_i;
      end else if (clr_w) begin
        pend_q[p] <= 1'b0;
      end
    end

    AST_MIDI_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q[p] && !(rd_take_i && rd_port_i == PW'(p)) |=> pend_q[p] && $stable(byte_q[p])); // R6
  end
endmodule

// File: rtl/cip_frame_buf.sv
module cip_frame_buf
  import cip_tx_pkg::*;
#(
  parameter int unsigned MAX_CH = 18,
  localparam int unsigned CH_W = $clog2(MAX_CH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [MAX_CH*SAMPLE_W-1:0] frame_i,
  input  logic [CH_W-1:0]            sel_i,
  output logic [31:0]                quad_o
);
  logic [SAMPLE_W-1:0] smp_q [MAX_CH];

  for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     smp_q[c] <= '0;
      else if (load_i) smp_q[c] <= frame_i[c*SAMPLE_W +: SAMPLE_W];
    end
  end

  assign quad_o = {LBL_PCM, smp_q[sel_i]};
endmodule

// File: rtl/am824_pkt_tx.sv
module am824_pkt_tx
  import cip_tx_pkg::*;
#(
  parameter int unsigned MAX_CH  = 18,
  parameter int unsigned MAX_BLK = 8,
  localparam int unsigned CH_W  = $clog2(MAX_CH + 1),
  localparam int unsigned BLK_W = $clog2(MAX_BLK + 1),
  localparam int unsigned LEN_W = $clog2(8 + MAX_BLK * (MAX_CH + 1) * 4 + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [5:0]                 cfg_node_i,
  input  logic [CH_W-1:0]            cfg_nch_i,
  input  logic [2:0]                 cfg_rate_i,
  input  logic [BLK_W-1:0]           cfg_nblk_i,
  input  logic                       pkt_start_i,
  input  logic                       frame_valid_i,
  input  logic [MAX_CH*SAMPLE_W-1:0] frame_data_i,
  output logic                       frame_ready_o,
  input  logic                       midi_valid_i,
  input  logic [2:0]                 midi_port_i,
  input  logic [7:0]                 midi_byte_i,
  output logic                       midi_ready_o,
  output logic                       q_valid_o,
  output logic [31:0]                q_data_o,
  output logic                       q_sop_o,
  output logic                       q_eop_o,
  output logic [LEN_W-1:0]           len_o
);
  state_e           state_q;
  logic             empty_q;
  logic [BLK_W-1:0] blk_q, nblk_q;
  logic [CH_W-1:0]  ch_q, nch_q;
  logic [7:0]       dbc_q;
  logic [5:0]       node_q;
  logic [2:0]       rate_q;
  logic [LEN_W-1:0] len_q;

  logic [7:0]  blk_idx;
  logic        take_w, last_ch, last_blk;
  logic        midi_hit;
  logic [7:0]  midi_byte;
  logic [31:0] pcm_quad;
  logic [LEN_W-1:0] len_calc;

  assign blk_idx  = dbc_q + 8'(blk_q);
  assign take_w   = (state_q == S_MIDI) && frame_valid_i;
  assign last_ch  = (ch_q == nch_q - 1'b1);
  assign last_blk = (blk_q == nblk_q - 1'b1);
  assign len_calc = LEN_W'(8) + LEN_W'(4) * LEN_W'(cfg_nblk_i) * (LEN_W'(cfg_nch_i) + LEN_W'(1));

  cip_midi_slots u_midi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (midi_valid_i),
    .wr_port_i  (midi_port_i),
    .wr_byte_i  (midi_byte_i),
    .wr_ready_o (midi_ready_o),
    .rd_port_i  (blk_idx[2:0]),
    .rd_take_i  (take_w),
    .rd_hit_o   (midi_hit),
    .rd_byte_o  (midi_byte)
  );

  cip_frame_buf #(.MAX_CH(MAX_CH)) u_fbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (take_w),
    .frame_i (frame_data_i),
    .sel_i   (ch_q),
    .quad_o  (pcm_quad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      empty_q <= 1'b0;
      blk_q   <= '0;
      nblk_q  <= '0;
      ch_q    <= '0;
      nch_q   <= '0;
      dbc_q   <= '0;
      node_q  <= '0;
      rate_q  <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (pkt_start_i) begin
          empty_q <= !frame_valid_i;
          node_q  <= cfg_node_i;
          rate_q  <= cfg_rate_i;
          nch_q   <= cfg_nch_i;
          nblk_q  <= cfg_nblk_i;
          blk_q   <= '0;
          ch_q    <= '0;
          len_q   <= frame_valid_i ? len_calc : LEN_W'(8);
          state_q <= S_HDR0;
        end
        S_HDR0: state_q <= S_HDR1;
        S_HDR1: state_q <= empty_q ? S_IDLE : S_MIDI;
        S_MIDI: if (frame_valid_i) begin
          ch_q    <= '0;
          state_q <= S_AUD;
        end
        S_AUD: begin
          if (!last_ch) begin
            ch_q <= ch_q + 1'b1;
          end else if (!last_blk) begin
            blk_q   <= blk_q + 1'b1;
            state_q <= S_MIDI;
          end else begin
            dbc_q   <= dbc_q + 8'(nblk_q);
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    q_valid_o = 1'b0;
    q_data_o  = '0;
    unique case (state_q)
      S_HDR0: begin
        q_valid_o = 1'b1;
        q_data_o  = {2'b00, node_q, 8'(nch_q) + 8'd1, 8'h00, dbc_q};
      end
      S_HDR1: begin
        q_valid_o = 1'b1;
        q_data_o  = {2'b10, FMT_AUDIO, 5'b0, rate_q, 16'h0000};
      end
      S_MIDI: begin
        q_valid_o = frame_valid_i;
        q_data_o  = midi_hit ? {LBL_MIDI_ONE, midi_byte, 16'h0000} : {LBL_MIDI_NONE, 24'h0};
      end
      S_AUD: begin
        q_valid_o = 1'b1;
        q_data_o  = pcm_quad;
      end
      default: ;
    endcase
  end

  assign q_sop_o       = (state_q == S_HDR0);
  assign q_eop_o       = ((state_q == S_HDR1) && empty_q) ||
                         ((state_q == S_AUD) && last_ch && last_blk);
  assign frame_ready_o = take_w;
  assign len_o         = len_q;

  AST_SOP_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_sop_o |-> $past(state_q) == S_IDLE); // R8
  AST_EOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o && q_eop_o |=> state_q == S_IDLE); // R8
  AST_EMPTY_KEEPS_DBC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_HDR1 && empty_q |=> dbc_q == $past(dbc_q)); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_MIDI && !frame_valid_i |=> state_q == S_MIDI && $stable(blk_q)); // R9
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_i && state_q != S_IDLE |=> $stable(nblk_q) && $stable(nch_q)); // R10
endmodule

// File: tb/am824_pkt_tx_bench.sv
module am824_pkt_tx_bench;
  localparam int MAX_CH = 18;
  localparam int MAX_BLK = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [5:0]  cfg_node = '0;
  logic [4:0]  cfg_nch = 5'd1;
  logic [2:0]  cfg_rate = '0;
  logic [3:0]  cfg_nblk = 4'd1;
  logic        pkt_start = 1'b0;
  logic        frame_valid = 1'b0;
  logic [MAX_CH*24-1:0] frame_data;
  logic        frame_ready;
  logic        midi_valid = 1'b0;
  logic [2:0]  midi_port = '0;
  logic [7:0]  midi_byte = '0;
  logic        midi_ready;
  logic        q_valid, q_sop, q_eop;
  logic [31:0] q_data;
  logic [9:0]  len;

  am824_pkt_tx u_am824_pkt_tx (
    .clk_i(clk), .rst_ni(rst_n), .cfg_node_i(cfg_node), .cfg_nch_i(cfg_nch),
    .cfg_rate_i(cfg_rate), .cfg_nblk_i(cfg_nblk), .pkt_start_i(pkt_start),
    .frame_valid_i(frame_valid), .frame_data_i(frame_data), .frame_ready_o(frame_ready),
    .midi_valid_i(midi_valid), .midi_port_i(midi_port), .midi_byte_i(midi_byte),
    .midi_ready_o(midi_ready), .q_valid_o(q_valid), .q_data_o(q_data),
    .q_sop_o(q_sop), .q_eop_o(q_eop), .len_o(len)
  );

  int checks = 0, fails = 0;
  logic [7:0] fcnt;
  logic [7:0] mdbc = '0;
  logic       mpend [8];
  logic [7:0] mbyte [8];

  always_comb
    for (int c = 0; c < MAX_CH; c++) frame_data[c*24 +: 24] = {fcnt, 8'(c), 8'h5A};

  always @(posedge clk or negedge rst_n)
    if (!rst_n) fcnt <= '0;
    else if (frame_ready) fcnt <= fcnt + 8'd1;

  logic [31:0] cap [256];
  logic        cap_sop [256];
  logic        cap_eop [256];
  logic [9:0]  cap_len;
  int          ncap = 0;
  logic        got_eop = 1'b0;

  always @(negedge clk)
    if (rst_n && q_valid) begin
      cap[ncap] = q_data; cap_sop[ncap] = q_sop; cap_eop[ncap] = q_eop;
      if (q_sop) cap_len = len;
      if (q_eop) got_eop = 1'b1;
      ncap++;
    end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  // run one packet; mode 0 normal, 1 mid-packet frame gap, 2 extra start pulse while busy
  task automatic run_pkt(input int nch, input int nblk, input int node, input int rate, input int mode);
    logic [31:0] exp [256];
    int nexp;
    logic [7:0] f0;
    bit empty;
    cfg_nch = 5'(nch); cfg_nblk = 4'(nblk); cfg_node = 6'(node); cfg_rate = 3'(rate);
    empty = !frame_valid;
    f0 = fcnt;
    exp[0] = {2'b00, 6'(node), 8'(nch + 1), 8'h00, mdbc};
    exp[1] = {2'b10, 6'h10, 5'b0, 3'(rate), 16'h0};
    nexp = 2;
    if (!empty)
      for (int b = 0; b < nblk; b++) begin
        int p = (int'(mdbc) + b) % 8;
        if (mpend[p]) begin exp[nexp] = {8'h81, mbyte[p], 16'h0}; mpend[p] = 1'b0; end
        else exp[nexp] = 32'h80000000;
        nexp++;
        for (int c = 0; c < nch; c++) begin
          exp[nexp] = {8'h40, 8'(f0 + 8'(b)), 8'(c), 8'h5A};
          nexp++;
        end
      end
    ncap = 0; got_eop = 1'b0;
    @(posedge clk); #1 pkt_start = 1'b1;
    @(posedge clk); #1 pkt_start = 1'b0;
    if (mode == 1) begin
      repeat (3) @(posedge clk);
      #1 frame_valid = 1'b0;
      repeat (5) @(posedge clk);
      #1 frame_valid = 1'b1;
    end
    if (mode == 2) begin
      repeat (3) @(posedge clk);
      #1 pkt_start = 1'b1;
      @(posedge clk); #1 pkt_start = 1'b0;
    end
    while (!got_eop) @(posedge clk);
    repeat (4) @(posedge clk);
    chk(ncap == nexp, mode == 2 ? "R10 quadlet count" : "R8 quadlet count", 32'(ncap), 32'(nexp));
    for (int i = 0; i < nexp && i < ncap; i++) begin
      string tag;
      if (i == 0) tag = "R1 header0";
      else if (i == 1) tag = "R2 header1";
      else if (exp[i][31:24] == 8'h40) tag = "R4 audio";
      else tag = "R5 midi";
      chk(cap[i] == exp[i], tag, cap[i], exp[i]);
      chk(cap_sop[i] == (i == 0) && cap_eop[i] == (i == nexp - 1), "R8 framing", 32'(i), 32'(nexp - 1));
    end
    chk(cap[0][7:0] == mdbc, "R3 dbc", 32'(cap[0][7:0]), 32'(mdbc));
    chk(cap_len == 10'(4 * nexp), empty ? "R7 len" : "R8 len", 32'(cap_len), 32'(4 * nexp));
    chk(fcnt == 8'(f0 + 8'(empty ? 0 : nblk)), empty ? "R7 frames used" : "R9 frames used",
        32'(fcnt), 32'(f0 + 8'(empty ? 0 : nblk)));
    if (!empty) mdbc = mdbc + 8'(nblk);
  endtask

  task automatic send_midi(input int port, input logic [7:0] b);
    bit exp_rdy = !mpend[port];
    @(posedge clk); #1 midi_valid = 1'b1; midi_port = 3'(port); midi_byte = b;
    #1 chk(midi_ready == exp_rdy, "R6 midi ready", 32'(midi_ready), 32'(exp_rdy));
    @(posedge clk); #1 midi_valid = 1'b0;
    if (exp_rdy) begin mpend[port] = 1'b1; mbyte[port] = b; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!q_valid, "R11 q_valid", 32'(q_valid), 0);
    chk(!frame_ready, "R11 frame_ready", 32'(frame_ready), 0);
    chk(midi_ready, "R11 midi_ready", 32'(midi_ready), 1);
  endtask

  task automatic t_midi();
    send_midi(3, 8'h33);
    send_midi(3, 8'h44);
    send_midi(0, 8'h10);
    send_midi(6, 8'h66);
    run_pkt(3, 4, 9, 2, 0);
    run_pkt(3, 4, 9, 2, 0);
    send_midi(3, 8'h55);
    run_pkt(2, 8, 9, 2, 0);
  endtask

  task automatic t_empty();
    frame_valid = 1'b0;
    run_pkt(4, 2, 1, 0, 0);
    frame_valid = 1'b1;
    run_pkt(4, 2, 1, 0, 0);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 32; k++) run_pkt(2, 8, 3, 1, 0);
  endtask

  initial begin
    for (int p = 0; p < 8; p++) begin mpend[p] = 1'b0; mbyte[p] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    frame_valid = 1'b1;
    run_pkt(4, 2, 5, 1, 0);
    run_pkt(18, 8, 63, 3, 0);
    t_midi();
    t_empty();
    run_pkt(5, 3, 2, 4, 1);
    run_pkt(4, 2, 7, 0, 2);
    t_wrap();
    finish_run();
  end
endmodule